// File: doc/BRIEF.md
# PCI Power State Controller

This block keeps the power management control and status register of one PCI function and tracks whether the function is fully on (D0) or in its low-power hot state (D3hot). A host configuration bus reads and writes the register by word address with per-byte enables. In D3hot the configuration space can still be reached. The block forces the memory decode, I/O decode and interrupt delivery enables low in that state.

When the function comes back from D3hot to D0, an external strap decides what happens to the configuration context. With the strap low, the block fires a one-cycle internal soft reset. That pulse wipes a small bank of context registers, which stand for the function's configuration context, and the function must then be set up again. With the strap high, the context survives the return to D0. The block also answers with a fixed read-only header word for the message-signalled interrupt capability. Every other address in its window reads as zero.

Top module: `pci_pwr_state_ctrl`

## Requirements
- R1: After reset the power register (byte address 0xCC) reads 0x00000000 when the strap is low, `soft_rst` is low and every context word reads zero.
- R2: In the power register, bits 31:4 and bit 2 always read zero whatever was written; bits 1:0 read the power state, 2'b00 for D0 and 2'b11 for D3hot.
- R3: A write of 2'b01 or 2'b10 to bits 1:0 leaves the power state unchanged.
- R4: Bit 3 of the power register always shows the current level of `nsr_strap`, and a write cannot change it.
- R5: With `nsr_strap` low at the write, a write that moves the state from 2'b11 to 2'b00 raises `soft_rst` for exactly one cycle, starting on the clock edge that commits the write. On the following edge every context word is cleared to zero and the state stays D0.
- R6: With `nsr_strap` high at the write, the move from D3hot to D0 gives no `soft_rst` pulse, and the context words keep their values.
- R7: In D3hot, `mem_en`, `io_en` and `irq_en` are all low. In D0, `io_en` equals context word 0 bit 0, `mem_en` equals context word 0 bit 1, and `irq_en` is the inverse of context word 0 bit 10.
- R8: Byte address 0xD0 always reads 0x00000005, which is capability ID 0x05 in bits 7:0 and next pointer 0x00 in bits 15:8. Writes to it have no effect on any readable state.
- R9: A write of 2'b11 while in D3hot, or of 2'b00 while in D0, changes nothing and gives no `soft_rst` pulse.
- R10: A write to the power register whose `cfg_be[0]` is low does not change the power state.
- R11: Four context words at byte addresses 0x10, 0x14, 0x18 and 0x1C are read/write, and each byte is updated only when its enable is set. Any address that is not a context word, the power register or the capability word reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | 8 | Byte address of the word being accessed |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| nsr_strap | input | 1 | High keeps the context across a D3hot-to-D0 return |
| mem_en | output | 1 | Memory decode enable |
| io_en | output | 1 | I/O decode enable |
| irq_en | output | 1 | Interrupt delivery enable |
| soft_rst | output | 1 | One-cycle internal reset pulse |

## Verification
The assertions check these on every cycle: the power state holds only a legal code, the three enables are low in D3hot, and the reserved bits and the strap bit read correctly. They also check that the capability word is fixed, and that any soft-reset pulse lasts one cycle, follows a D3hot-to-D0 move made with the strap low, and is followed by an empty context bank. Only the bench scenarios can show the other half. That covers moves that must not happen: illegal codes, same-state writes, writes with byte 0 disabled, and returns with the strap high. It also covers byte-merged context writes and the context surviving or being lost.

// File: rtl/pps_pkg.sv
package pps_pkg;
    localparam logic [1:0] PS_D0   = 2'b00;
    localparam logic [1:0] PS_D3   = 2'b11;
    localparam logic [7:0] MSI_CID = 8'h05;
    localparam logic [7:0] CAP_NXT = 8'h00;

    typedef struct packed {
        logic [1:0] ps;
        logic       srst;
    } pps_state_t;
endpackage

// File: rtl/pps_state.sv
module pps_state
    import pps_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PMCS_ADDR = 8'hCC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        wr_ps,
    input  logic              be0,
    input  logic              strap,
    output logic [1:0]        ps,
    output logic              srst
);
    pps_state_t st_d, st_q;
    logic       hit;
    logic       legal;

    assign hit   = wr_en && (addr == PMCS_ADDR) && be0;
    assign legal = (wr_ps == PS_D0) || (wr_ps == PS_D3);

    always_comb begin
        st_d      = st_q;
        st_d.srst = 1'b0;
        if (st_q.srst) begin
            st_d.ps = PS_D0;
        end
        if (hit && legal) begin
            st_d.ps = wr_ps;
            if ((st_q.ps == PS_D3) && (wr_ps == PS_D0) && !strap) begin
                st_d.srst = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ps: PS_D0, srst: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ps   = st_q.ps;
    assign srst = st_q.srst;
endmodule

// File: rtl/pps_ctx.sv
module pps_ctx #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTX_BASE  = 8'h10,
    parameter int                CTX_WORDS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [31:0]             wdata,
    input  logic [3:0]              be,
    output logic [CTX_WORDS*32-1:0] ctx_flat
);
    localparam int AW2 = ADDR_W - 2;

    for (genvar g = 0; g < CTX_WORDS; g++) begin : g_word
        localparam logic [AW2-1:0] WIDX = AW2'(CTX_BASE >> 2) + AW2'(g);
        logic [31:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (clr) begin
                word_d = '0;
            end else if (wr_en && (addr == {WIDX, 2'b00})) begin
                for (int b = 0; b < 4; b++) begin
                    if (be[b]) begin
                        word_d[8*b +: 8] = wdata[8*b +: 8];
                    end
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= word_d;
            end
        end

        assign ctx_flat[32*g +: 32] = word_q;
    end
endmodule

// File: rtl/pps_rdmux.sv
module pps_rdmux
    import pps_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PMCS_ADDR = 8'hCC,
    parameter logic [ADDR_W-1:0] CAP_ADDR  = 8'hD0,
    parameter logic [ADDR_W-1:0] CTX_BASE  = 8'h10,
    parameter int                CTX_WORDS = 4
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [1:0]              ps,
    input  logic                    strap,
    input  logic [CTX_WORDS*32-1:0] ctx_flat,
    output logic [31:0]             rdata
);
    localparam int AW2 = ADDR_W - 2;

    always_comb begin
        rdata = '0;
        if (addr == PMCS_ADDR) begin
            rdata = {28'd0, strap, 1'b0, ps};
        end else if (addr == CAP_ADDR) begin
            rdata = {16'd0, CAP_NXT, MSI_CID};
        end else begin
            for (int i = 0; i < CTX_WORDS; i++) begin
                if (addr == {AW2'(CTX_BASE >> 2) + AW2'(i), 2'b00}) begin
                    rdata = ctx_flat[32*i +: 32];
                end
            end
        end
    end
endmodule

// File: rtl/pci_pwr_state_ctrl.sv
module pci_pwr_state_ctrl
    import pps_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PMCS_ADDR = 8'hCC,
    parameter logic [ADDR_W-1:0] CAP_ADDR  = 8'hD0,
    parameter logic [ADDR_W-1:0] CTX_BASE  = 8'h10,
    parameter int                CTX_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [3:0]        cfg_be,
    output logic [31:0]       cfg_rdata,
    input  logic              nsr_strap,
    output logic              mem_en,
    output logic              io_en,
    output logic              irq_en,
    output logic              soft_rst
);
    logic [1:0]              ps;
    logic [CTX_WORDS*32-1:0] ctx_flat;
    logic [31:0]             ctx0;
    logic                    in_d0;

    pps_state #(.ADDR_W(ADDR_W), .PMCS_ADDR(PMCS_ADDR)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .addr  (cfg_addr),
        .wr_ps (cfg_wdata[1:0]),
        .be0   (cfg_be[0]),
        .strap (nsr_strap),
        .ps    (ps),
        .srst  (soft_rst)
    );

    pps_ctx #(.ADDR_W(ADDR_W), .CTX_BASE(CTX_BASE), .CTX_WORDS(CTX_WORDS)) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .wr_en    (cfg_wr),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .be       (cfg_be),
        .ctx_flat (ctx_flat)
    );

    pps_rdmux #(
        .ADDR_W(ADDR_W), .PMCS_ADDR(PMCS_ADDR), .CAP_ADDR(CAP_ADDR),
        .CTX_BASE(CTX_BASE), .CTX_WORDS(CTX_WORDS)
    ) u_rd (
        .addr     (cfg_addr),
        .ps       (ps),
        .strap    (nsr_strap),
        .ctx_flat (ctx_flat),
        .rdata    (cfg_rdata)
    );

    assign ctx0   = ctx_flat[31:0];
    assign in_d0  = (ps == PS_D0);
    assign io_en  = in_d0 & ctx0[0];
    assign mem_en = in_d0 & ctx0[1];
    assign irq_en = in_d0 & ~ctx0[10];
endmodule

// File: rtl/pci_pwr_state_ctrl_chk.sv
module pci_pwr_state_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  ps,
    input logic        soft_rst,
    input logic        nsr_strap,
    input logic        mem_en,
    input logic        io_en,
    input logic        irq_en,
    input logic [31:0] ctx0,
    input logic [7:0]  cfg_addr,
    input logic [31:0] cfg_rdata
);
    p_ps_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ps == 2'b00) || (ps == 2'b11));

    p_d3_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ps == 2'b11) |-> (!mem_en && !io_en && !irq_en));

    p_pulse_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> ($past(ps) == 2'b11 && ps == 2'b00));

    p_ctx_wipe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ctx0 == 32'd0));

    p_strap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> !$past(nsr_strap));

    p_cap_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 8'hD0) |-> (cfg_rdata == 32'h0000_0005));

    // R2 and R4: reserved bits zero, bit 3 mirrors the strap
    p_pm_view_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 8'hCC) |->
            (cfg_rdata[31:4] == 28'd0 && !cfg_rdata[2] && cfg_rdata[3] == nsr_strap));
endmodule

bind pci_pwr_state_ctrl pci_pwr_state_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ps        (ps),
    .soft_rst  (soft_rst),
    .nsr_strap (nsr_strap),
    .mem_en    (mem_en),
    .io_en     (io_en),
    .irq_en    (irq_en),
    .ctx0      (ctx0),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata)
);

// File: tb/pci_pwr_state_ctrl_tb.sv
module pci_pwr_state_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_rdata;
    logic        nsr_strap = 1'b0;
    logic        mem_en, io_en, irq_en, soft_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_pwr_state_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
        .nsr_strap(nsr_strap), .mem_en(mem_en), .io_en(io_en),
        .irq_en(irq_en), .soft_rst(soft_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'hCC, v); check("R1 pm reg", v, 32'h0);
        check("R1 soft_rst", {31'd0, soft_rst}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            rd(8'h10 + 8'(4*i), v); check("R1 ctx word", v, 32'h0);
        end
        check("R7 enables in D0 after reset", {29'd0, mem_en, io_en, irq_en}, 32'b001);
    endtask

    task automatic t_ctx_bank();
        logic [31:0] v;
        wr(8'h10, 32'hA5A5_0003, 4'hF);
        rd(8'h10, v); check("R11 full write", v, 32'hA5A5_0003);
        wr(8'h14, 32'h1122_3344, 4'b0101);
        rd(8'h14, v); check("R11 byte merge", v, 32'h0022_0044);
        wr(8'h1C, 32'hDEAD_BEEF, 4'hF);
        rd(8'h1C, v); check("R11 last word", v, 32'hDEAD_BEEF);
        rd(8'h20, v); check("R11 unmapped reads zero", v, 32'h0);
        check("R7 enables follow ctx in D0", {29'd0, mem_en, io_en, irq_en}, 32'b111);
    endtask

    task automatic t_enter_d3();
        logic [31:0] v;
        wr(8'hCC, 32'h3, 4'h1);
        rd(8'hCC, v); check("R2 D3hot code", v, 32'h3);
        check("R7 gated in D3hot", {29'd0, mem_en, io_en, irq_en}, 32'b000);
    endtask

    task automatic t_illegal();
        logic [31:0] v;
        wr(8'hCC, 32'h1, 4'h1);
        rd(8'hCC, v); check("R3 write 01 ignored", v, 32'h3);
        wr(8'hCC, 32'h2, 4'h1);
        rd(8'hCC, v); check("R3 write 10 ignored", v, 32'h3);
    endtask

    task automatic t_same_d3();
        logic [31:0] v;
        wr(8'hCC, 32'h3, 4'h1);
        check("R9 no pulse D3 to D3", {31'd0, soft_rst}, 32'd0);
        rd(8'hCC, v); check("R9 still D3", v, 32'h3);
    endtask

    task automatic t_byte_en();
        logic [31:0] v;
        wr(8'hCC, 32'h0, 4'b1110);
        check("R10 no pulse without be0", {31'd0, soft_rst}, 32'd0);
        rd(8'hCC, v); check("R10 state kept", v, 32'h3);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        nsr_strap = 1'b0;
        wr(8'hCC, 32'h0, 4'h1);
        check("R5 pulse high", {31'd0, soft_rst}, 32'd1);
        rd(8'h10, v); check("R5 ctx not yet cleared", v, 32'hA5A5_0003);
        @(negedge clk);
        check("R5 pulse one cycle", {31'd0, soft_rst}, 32'd0);
        rd(8'h10, v); check("R5 ctx word0 cleared", v, 32'h0);
        rd(8'h1C, v); check("R5 ctx word3 cleared", v, 32'h0);
        rd(8'hCC, v); check("R5 back in D0", v, 32'h0);
        check("R7 enables after wipe", {29'd0, mem_en, io_en, irq_en}, 32'b001);
    endtask

    task automatic t_keep_ctx();
        logic [31:0] v;
        wr(8'h10, 32'h0000_0402, 4'hF);
        check("R7 irq masked by ctx bit10", {29'd0, mem_en, io_en, irq_en}, 32'b100);
        wr(8'hCC, 32'h3, 4'h1);
        nsr_strap = 1'b1;
        wr(8'hCC, 32'h0, 4'h1);
        check("R6 no pulse", {31'd0, soft_rst}, 32'd0);
        @(negedge clk);
        check("R6 still no pulse", {31'd0, soft_rst}, 32'd0);
        rd(8'h10, v); check("R6 ctx kept", v, 32'h0000_0402);
        rd(8'hCC, v); check("R4 strap shows in bit3", v, 32'h8);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr(8'hCC, 32'hFFFF_FFF7, 4'hF);
        rd(8'hCC, v); check("R2 reserved read zero", v, 32'hB);
        nsr_strap = 1'b0;
        rd(8'hCC, v); check("R4 strap low live", v, 32'h3);
        nsr_strap = 1'b1;
        wr(8'hCC, 32'h0000_0000, 4'hF);
        rd(8'hCC, v); check("R4 bit3 not writable", v, 32'h8);
    endtask

    task automatic t_cap();
        logic [31:0] v;
        rd(8'hD0, v); check("R8 cap word", v, 32'h5);
        wr(8'hD0, 32'hFFFF_FFFF, 4'hF);
        rd(8'hD0, v); check("R8 cap after write", v, 32'h5);
        rd(8'h10, v); check("R8 write left ctx alone", v, 32'h0000_0402);
        rd(8'hCC, v); check("R8 write left pm alone", v, 32'h8);
    endtask

    task automatic t_same_d0();
        wr(8'hCC, 32'h0, 4'h1);
        check("R9 no pulse D0 to D0", {31'd0, soft_rst}, 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctx_bank();
        t_enter_d3();
        t_illegal();
        t_same_d3();
        t_byte_en();
        t_soft_reset();
        t_keep_ctx();
        t_reserved();
        t_cap();
        t_same_d0();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule